// File: doc/BRIEF.md
# Hash Engine Control Register File

This block is the register-bus front end of a memory-to-memory hash accelerator. Software writes a source pointer, a digest pointer, a key-buffer pointer and a byte count over a plain 32-bit bus. Each bus cycle carries an address, a write enable and write data, and read data comes back one cycle later. The block masks each pointer to the address range that the engine can reach. The digest and key pointers are also forced to 8-byte alignment. A write to the hash command word latches the mode fields and sends a one-cycle start pulse to the external engine.

The engine reports activity on three busy lines, for the hash, cipher and public-key units. It reports completion on three done strobes. The done strobes set sticky status bits, which software clears by writing ones to them. The interrupt line stays high while any of these sticky bits is set. The block decodes the algorithm field into a compact code for the engine. It also passes on the output byte-order options and the scatter-gather enable. None of these outputs changes while the hash unit reports busy.

Top module: `hash_ctl_regs`

## Requirements
- R1: After synchronous reset, every register reads 0, including status. The irq and eng_start outputs are low.
- R2: The source pointer at offset 0x20 keeps only the written bits under mask 0x7FFFFFFF. Its value drives eng_src.
- R3: The digest pointer at 0x24 and the key pointer at 0x28 keep only the bits under mask 0x7FFFFFF8, so their low three bits always read 0.
- R4: The length register at 0x2C keeps only bits 27:0 (mask 0x0FFFFFFF).
- R5: The general command word at 0x10 stores the write data under mask 0x0004047C. Writing it produces no start pulse.
- R6: A write to the hash command word at 0x30 while hash_busy_i is low has three effects. It stores the data under mask 0x0004047C. It raises eng_start for exactly the one cycle after the write. It updates the mode outputs: eng_sha_be from bit 3, eng_md5_le from bit 2 and eng_sg from bit 18.
- R7: A write to 0x30 while hash_busy_i is high is ignored. No pulse is sent, and the stored word and the mode outputs keep their values.
- R8: eng_alg decodes bits {10,6,5,4} of the latched command into a code. 0000 gives MD5 (0). 0010 gives SHA-1 (1). 0100 gives SHA-224 (2). 0101 gives SHA-256 (3). 1110 gives SHA-384 (4). 0110 gives SHA-512 (5). Every other pattern gives 7 (invalid).
- R9: Status at 0x1C has three live busy bits: hash at bit 0, cipher at bit 1 and public-key at bit 2. A done strobe sets a sticky bit at the edge where it is sampled: hash at bit 9, cipher at bit 12, public-key at bit 13. After only a hash completion, status reads exactly 0x00000200.
- R10: Writing status clears each sticky bit whose data bit is 1 and leaves the bits written as 0 unchanged. A done strobe in the same cycle as a clear of the same bit wins, so the bit stays set.
- R11: irq is high exactly while at least one sticky done bit is set. It rises and falls on the same edge as the bits.
- R12: Offsets not listed above read 0 and ignore writes. Unimplemented bits of every register read 0. Read data appears one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| hash_busy_i | input | 1 | Hash unit busy |
| crypt_busy_i | input | 1 | Cipher unit busy |
| pk_busy_i | input | 1 | Public-key unit busy |
| hash_done_i | input | 1 | Hash job completion strobe |
| crypt_done_i | input | 1 | Cipher job completion strobe |
| pk_done_i | input | 1 | Public-key job completion strobe |
| eng_start | output | 1 | One-cycle job start pulse |
| eng_alg | output | 3 | Decoded algorithm code |
| eng_sha_be | output | 1 | Big-endian SHA digest output |
| eng_md5_le | output | 1 | Little-endian MD5 digest output |
| eng_sg | output | 1 | Scatter-gather source mode |
| eng_src | output | 32 | Masked source pointer |
| eng_dst | output | 32 | Masked, aligned digest pointer |
| eng_key | output | 32 | Masked, aligned key pointer |
| eng_len | output | 32 | Masked byte count |
| irq | output | 1 | Completion interrupt |

## Verification
The bench walks a single set bit and an all-ones word through every pointer register. A wrong mask would show up as a stray top bit or an unaligned digest pointer. All sixteen patterns of the four algorithm bits are swept, so a decoder that matches too loosely would report an invalid mode as a real algorithm. Every mix of set sticky bits is tried against every clear pattern, which exposes a clear that also hits bits written as 0, or one that misses bits written as 1. The bench also drives a done strobe and a clear of the same bit in one cycle, and writes the hash command while the hash unit is busy. A design that lost that race, or that restarted or changed modes while busy, would fail these checks.

// File: rtl/hre_pkg.sv
package hre_pkg;
  localparam int OFF_CTL  = 8'h10;
  localparam int OFF_STS  = 8'h1C;
  localparam int OFF_SRC  = 8'h20;
  localparam int OFF_HCMD = 8'h30;

  localparam int BIT_MD5_LE = 2;
  localparam int BIT_SHA_BE = 3;
  localparam int BIT_SG     = 18;

  localparam int BIT_HDONE  = 9;
  localparam int BIT_CDONE  = 12;
  localparam int BIT_PDONE  = 13;

  typedef enum logic [2:0] {
    ALG_MD5    = 3'd0,
    ALG_SHA1   = 3'd1,
    ALG_SHA224 = 3'd2,
    ALG_SHA256 = 3'd3,
    ALG_SHA384 = 3'd4,
    ALG_SHA512 = 3'd5,
    ALG_BAD    = 3'd7
  } hre_alg_e;

  function automatic hre_alg_e alg_decode(input logic [3:0] sel);
    // sel = {bit10, bit6, bit5, bit4} of the command word
    case (sel)
      4'b0000: alg_decode = ALG_MD5;
      4'b0010: alg_decode = ALG_SHA1;
      4'b0100: alg_decode = ALG_SHA224;
      4'b0101: alg_decode = ALG_SHA256;
      4'b1110: alg_decode = ALG_SHA384;
      4'b0110: alg_decode = ALG_SHA512;
      default: alg_decode = ALG_BAD;
    endcase
  endfunction
endpackage

// File: rtl/hre_field_reg.sv
module hre_field_reg #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int OFFSET = 0,
  parameter logic [DW-1:0] MASK = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam logic [AW-1:0] MY_ADDR = AW'(OFFSET);

  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (we && addr == MY_ADDR)
      q <= wdata & MASK;
  end
endmodule

// File: rtl/hre_job.sv
module hre_job
  import hre_pkg::*;
#(
  parameter int DW = 32,
  parameter logic [DW-1:0] MODE_MASK = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_we,
  input  logic [DW-1:0] wdata,
  input  logic          busy,
  output logic [DW-1:0] mode_q,
  output logic          start_q,
  output hre_alg_e      alg_q,
  output logic          sha_be_q,
  output logic          md5_le_q,
  output logic          sg_q
);
  logic           accept;
  logic [DW-1:0]  mode_d;

  assign accept = cmd_we && !busy;
  assign mode_d = wdata & MODE_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      start_q  <= 1'b0;
      alg_q    <= ALG_MD5;
      sha_be_q <= 1'b0;
      md5_le_q <= 1'b0;
      sg_q     <= 1'b0;
    end else begin
      start_q <= accept;
      if (accept) begin
        mode_q   <= mode_d;
        alg_q    <= alg_decode({mode_d[10], mode_d[6], mode_d[5], mode_d[4]});
        sha_be_q <= mode_d[BIT_SHA_BE];
        md5_le_q <= mode_d[BIT_MD5_LE];
        sg_q     <= mode_d[BIT_SG];
      end
    end
  end
endmodule

// File: rtl/hre_status.sv
module hre_status
  import hre_pkg::*;
#(
  parameter int DW = 32,
  parameter int NU = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sts_we,
  input  logic [NU-1:0] clr_bits,
  input  logic [NU-1:0] busy_in,
  input  logic [NU-1:0] done_in,
  output logic [DW-1:0] sts_word,
  output logic [NU-1:0] done_q,
  output logic          irq_q
);
  logic [NU-1:0] done_d;

  // a strobe that lands with a clear keeps the bit set
  assign done_d = (done_q & ~(sts_we ? clr_bits : '0)) | done_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      irq_q  <= |done_d;
    end
  end

  always_comb begin
    sts_word = '0;
    sts_word[NU-1:0] = busy_in;
    sts_word[BIT_HDONE] = done_q[0];
    sts_word[BIT_CDONE] = done_q[1];
    sts_word[BIT_PDONE] = done_q[2];
  end
endmodule

// File: rtl/hash_ctl_regs.sv
module hash_ctl_regs
  import hre_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [DW-1:0] SRC_MASK  = 32'h7FFF_FFFF,
  parameter logic [DW-1:0] DST_MASK  = 32'h7FFF_FFF8,
  parameter logic [DW-1:0] LEN_MASK  = 32'h0FFF_FFFF,
  parameter logic [DW-1:0] MODE_MASK = 32'h0004_047C
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          hash_busy_i,
  input  logic          crypt_busy_i,
  input  logic          pk_busy_i,
  input  logic          hash_done_i,
  input  logic          crypt_done_i,
  input  logic          pk_done_i,
  output logic          eng_start,
  output logic [2:0]    eng_alg,
  output logic          eng_sha_be,
  output logic          eng_md5_le,
  output logic          eng_sg,
  output logic [DW-1:0] eng_src,
  output logic [DW-1:0] eng_dst,
  output logic [DW-1:0] eng_key,
  output logic [DW-1:0] eng_len,
  output logic          irq
);
  localparam int NPTR = 4;   // source, digest, key, length: consecutive words
  localparam int NU   = 3;
  localparam logic [AW-1:0] A_CTL  = AW'(OFF_CTL);
  localparam logic [AW-1:0] A_STS  = AW'(OFF_STS);
  localparam logic [AW-1:0] A_HCMD = AW'(OFF_HCMD);

  logic [NPTR-1:0][DW-1:0] ptr_q;
  logic [DW-1:0]           ctl_q;
  logic [DW-1:0]           mode_q;
  logic [DW-1:0]           sts_word;
  logic [NU-1:0]           done_q;
  hre_alg_e                alg_q;
  logic                    cmd_we;
  logic                    sts_we;

  assign cmd_we = bus_we && bus_addr == A_HCMD;
  assign sts_we = bus_we && bus_addr == A_STS;

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    localparam logic [DW-1:0] M = (i == 0) ? SRC_MASK :
                                  (i == NPTR - 1) ? LEN_MASK : DST_MASK;
    hre_field_reg #(.AW(AW), .DW(DW), .OFFSET(OFF_SRC + 4 * i), .MASK(M)) u_reg (
      .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr),
      .wdata(bus_wdata), .q(ptr_q[i])
    );
  end

  hre_field_reg #(.AW(AW), .DW(DW), .OFFSET(OFF_CTL), .MASK(MODE_MASK)) u_ctl (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .q(ctl_q)
  );

  hre_job #(.DW(DW), .MODE_MASK(MODE_MASK)) u_job (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .wdata(bus_wdata),
    .busy(hash_busy_i), .mode_q(mode_q), .start_q(eng_start),
    .alg_q(alg_q), .sha_be_q(eng_sha_be), .md5_le_q(eng_md5_le), .sg_q(eng_sg)
  );

  hre_status #(.DW(DW), .NU(NU)) u_sts (
    .clk(clk), .rst(rst), .sts_we(sts_we),
    .clr_bits({bus_wdata[BIT_PDONE], bus_wdata[BIT_CDONE], bus_wdata[BIT_HDONE]}),
    .busy_in({pk_busy_i, crypt_busy_i, hash_busy_i}),
    .done_in({pk_done_i, crypt_done_i, hash_done_i}),
    .sts_word(sts_word), .done_q(done_q), .irq_q(irq)
  );

  assign eng_alg = alg_q;
  assign eng_src = ptr_q[0];
  assign eng_dst = ptr_q[1];
  assign eng_key = ptr_q[2];
  assign eng_len = ptr_q[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      if (bus_addr == A_CTL)  bus_rdata <= ctl_q;
      if (bus_addr == A_STS)  bus_rdata <= sts_word;
      if (bus_addr == A_HCMD) bus_rdata <= mode_q;
      for (int k = 0; k < NPTR; k++)
        if (bus_addr == AW'(OFF_SRC + 4 * k)) bus_rdata <= ptr_q[k];
    end
  end
endmodule

// File: rtl/hash_ctl_regs_chk.sv
module hash_ctl_regs_chk
  import hre_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] bus_addr,
  input logic          bus_we,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          hash_busy_i,
  input logic          hash_done_i,
  input logic          crypt_done_i,
  input logic          pk_done_i,
  input logic          eng_start,
  input logic [DW-1:0] mode_q,
  input logic [DW-1:0] eng_dst,
  input logic          irq
);
  // R6 / R7: a pulse only follows an accepted hash command write
  p_start_src_r6: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> $past(bus_we && bus_addr == AW'(OFF_HCMD) && !hash_busy_i));

  // R7: latched mode holds while the hash unit is busy
  p_mode_hold_r7: assert property (@(posedge clk) disable iff (rst)
    $past(hash_busy_i) |-> $stable(mode_q));

  // R3: digest pointer stays 8-byte aligned
  p_dst_align_r3: assert property (@(posedge clk) disable iff (rst)
    eng_dst[2:0] == 3'b000);

  // R11: a hash done strobe raises irq at the next edge
  p_irq_set_r11: assert property (@(posedge clk) disable iff (rst)
    $past(hash_done_i) |-> irq);

  // R10 / R11: clearing all sticky bits with no strobe drops irq
  p_irq_clr_r10: assert property (@(posedge clk) disable iff (rst)
    $past(bus_we && bus_addr == AW'(OFF_STS) && bus_wdata[BIT_HDONE]
          && bus_wdata[BIT_CDONE] && bus_wdata[BIT_PDONE]
          && !hash_done_i && !crypt_done_i && !pk_done_i) |-> !irq);

  // R9: busy bit 0 of a status read mirrors the hash busy line
  p_sts_busy_r9: assert property (@(posedge clk) disable iff (rst)
    $past(bus_addr == AW'(OFF_STS)) |-> bus_rdata[0] == $past(hash_busy_i));
endmodule

bind hash_ctl_regs hash_ctl_regs_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hash_busy_i(hash_busy_i),
  .hash_done_i(hash_done_i), .crypt_done_i(crypt_done_i), .pk_done_i(pk_done_i),
  .eng_start(eng_start), .mode_q(mode_q), .eng_dst(eng_dst), .irq(irq)
);

// File: tb/hash_ctl_regs_bench.sv
`timescale 1ns/1ps
module hash_ctl_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        hash_busy_i = 0, crypt_busy_i = 0, pk_busy_i = 0;
  logic        hash_done_i = 0, crypt_done_i = 0, pk_done_i = 0;
  logic        eng_start, eng_sha_be, eng_md5_le, eng_sg, irq;
  logic [2:0]  eng_alg;
  logic [31:0] eng_src, eng_dst, eng_key, eng_len;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hash_ctl_regs u_hash_ctl_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hash_busy_i(hash_busy_i), .crypt_busy_i(crypt_busy_i), .pk_busy_i(pk_busy_i),
    .hash_done_i(hash_done_i), .crypt_done_i(crypt_done_i), .pk_done_i(pk_done_i),
    .eng_start(eng_start), .eng_alg(eng_alg), .eng_sha_be(eng_sha_be),
    .eng_md5_le(eng_md5_le), .eng_sg(eng_sg), .eng_src(eng_src),
    .eng_dst(eng_dst), .eng_key(eng_key), .eng_len(eng_len), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic logic [2:0] exp_alg(input logic [31:0] w);
    logic [3:0] s;
    s = {w[10], w[6], w[5], w[4]};
    if (s == 4'b0000) return 3'd0;
    if (s == 4'b0010) return 3'd1;
    if (s == 4'b0100) return 3'd2;
    if (s == 4'b0101) return 3'd3;
    if (s == 4'b1110) return 3'd4;
    if (s == 4'b0110) return 3'd5;
    return 3'd7;
  endfunction

  function automatic logic [31:0] sts_of(input logic [2:0] d);
    return (32'(d[0]) << 9) | (32'(d[1]) << 12) | (32'(d[2]) << 13);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, w, prev;
    logic [7:0]  offs [4];
    logic [31:0] msks [4];
    offs = '{8'h20, 8'h24, 8'h28, 8'h2C};
    msks = '{32'h7FFFFFFF, 32'h7FFFFFF8, 32'h7FFFFFF8, 32'h0FFFFFFF};

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset values
    foreach (offs[i]) begin rd(offs[i], r); chk("R1 ptr", r, 0); end
    rd(8'h10, r); chk("R1 ctl", r, 0);
    rd(8'h1C, r); chk("R1 sts", r, 0);
    rd(8'h30, r); chk("R1 hcmd", r, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 start", {31'b0, eng_start}, 0);

    // R2 R3 R4: mask sweep over a walking one and all ones
    for (int k = 0; k < 4; k++) begin
      for (int b = 0; b <= 32; b++) begin
        w = (b == 32) ? 32'hFFFFFFFF : (32'h1 << b);
        wr(offs[k], w);
        rd(offs[k], r);
        case (k)
          0: chk("R2 src mask", r, w & msks[k]);
          1: chk("R3 dst mask", r, w & msks[k]);
          2: chk("R3 key mask", r, w & msks[k]);
          default: chk("R4 len mask", r, w & msks[k]);
        endcase
      end
    end
    chk("R2 eng_src", eng_src, 32'h7FFFFFFF);
    chk("R3 eng_dst", eng_dst, 32'h7FFFFFF8);
    chk("R3 eng_key", eng_key, 32'h7FFFFFF8);
    chk("R4 eng_len", eng_len, 32'h0FFFFFFF);

    // R5: general command stores masked value, no start
    bus_we = 1'b1; bus_addr = 8'h10; bus_wdata = 32'hFFFFFFFF;
    @(negedge clk); bus_we = 1'b0;
    chk("R5 no start", {31'b0, eng_start}, 0);
    rd(8'h10, r); chk("R5 ctl mask", r, 32'h0004047C);

    // R6 R8: sweep all algorithm selector patterns
    for (int p = 0; p < 16; p++) begin
      w = (32'(p[3]) << 10) | (32'(p[2]) << 6) | (32'(p[1]) << 5) | (32'(p[0]) << 4)
          | ((p % 2 == 1) ? 32'h0000_0008 : 32'h0004_0004) | 32'hFFF0_0000;
      bus_we = 1'b1; bus_addr = 8'h30; bus_wdata = w;
      @(negedge clk); bus_we = 1'b0;
      chk("R6 start pulse", {31'b0, eng_start}, 1);
      chk("R8 alg", {29'b0, eng_alg}, {29'b0, exp_alg(w)});
      chk("R6 sha_be", {31'b0, eng_sha_be}, {31'b0, w[3]});
      chk("R6 md5_le", {31'b0, eng_md5_le}, {31'b0, w[2]});
      chk("R6 sg", {31'b0, eng_sg}, {31'b0, w[18]});
      rd(8'h30, r);
      chk("R6 start one cycle", {31'b0, eng_start}, 0);
      chk("R6 hcmd readback", r, w & 32'h0004047C);
    end

    // R7: command while busy is ignored
    wr(8'h30, 32'h0000_0050);   // SHA-256
    @(negedge clk);
    prev = 32'h0000_0050;
    hash_busy_i = 1'b1;
    bus_we = 1'b1; bus_addr = 8'h30; bus_wdata = 32'h0004_0468;
    @(negedge clk); bus_we = 1'b0;
    chk("R7 no start", {31'b0, eng_start}, 0);
    rd(8'h30, r);
    chk("R7 no start later", {31'b0, eng_start}, 0);
    chk("R7 mode kept", r, prev);
    chk("R7 alg kept", {29'b0, eng_alg}, 32'd3);
    chk("R7 sg kept", {31'b0, eng_sg}, 0);

    // R9: busy mirrors
    crypt_busy_i = 1'b1; pk_busy_i = 1'b1;
    rd(8'h1C, r); chk("R9 busy bits", r, 32'h7);
    hash_busy_i = 0; crypt_busy_i = 0; pk_busy_i = 0;
    rd(8'h1C, r); chk("R9 idle", r, 0);

    // R9 R11: hash completion
    hash_done_i = 1'b1; @(negedge clk); hash_done_i = 1'b0;
    chk("R11 irq high", {31'b0, irq}, 1);
    rd(8'h1C, r); chk("R9 hash done", r, 32'h0000_0200);
    wr(8'h1C, 32'h0000_0200);
    chk("R11 irq low", {31'b0, irq}, 0);
    rd(8'h1C, r); chk("R10 cleared", r, 0);

    // R10 R11: every sticky pattern against every clear pattern
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 8; c++) begin
        hash_done_i = s[0]; crypt_done_i = s[1]; pk_done_i = s[2];
        @(negedge clk);
        hash_done_i = 0; crypt_done_i = 0; pk_done_i = 0;
        wr(8'h1C, sts_of(3'(c)) | 32'hFFFF_C1FF);
        rd(8'h1C, r);
        chk("R10 w1c", r, sts_of(3'(s) & ~3'(c)));
        chk("R11 irq", {31'b0, irq}, {31'b0, |(3'(s) & ~3'(c))});
        wr(8'h1C, 32'h0000_3200);
      end
    end

    // R10: strobe wins over clear in the same cycle
    hash_done_i = 1'b1; @(negedge clk);
    bus_we = 1'b1; bus_addr = 8'h1C; bus_wdata = 32'h0000_0200;
    @(negedge clk); bus_we = 1'b0; hash_done_i = 1'b0;
    rd(8'h1C, r); chk("R10 set wins", r, 32'h0000_0200);
    chk("R11 irq kept", {31'b0, irq}, 1);
    wr(8'h1C, 32'h0000_0200);

    // R12: unused offsets
    wr(8'h20, 32'h1234_5678);
    wr(8'h00, 32'hFFFFFFFF); wr(8'h14, 32'hFFFFFFFF);
    wr(8'h34, 32'hFFFFFFFF); wr(8'h21, 32'hFFFFFFFF);
    rd(8'h00, r); chk("R12 hole 00", r, 0);
    rd(8'h14, r); chk("R12 hole 14", r, 0);
    rd(8'h34, r); chk("R12 hole 34", r, 0);
    rd(8'h21, r); chk("R12 hole 21", r, 0);
    rd(8'h20, r); chk("R12 src untouched", r, 32'h1234_5678);
    rd(8'h1C, r); chk("R12 sts untouched", r, 0);
    chk("R12 no start", {31'b0, eng_start}, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule